// File: doc/BRIEF.md
# Free-Running Up-Counter with Prescaler

This block keeps a read-only count that rises steadily from the bus clock. The register block supplies three controls: an enable, an 8-bit prescale value and a halt-select bit. A debug-halt input comes from the processor side. While the counter is enabled, it advances once every (prescale + 1) bus clocks. It wraps silently from all ones to zero.

Software cannot write or clear the count. Only the system reset returns it to zero. Turning the enable off freezes the count where it stands. Turning the enable back on gives an increment on the very next clock, with no wait for a full prescale period. When halt-select is set and the debug-halt input is high, the count and the prescaler phase both hold. When the halt is released, counting resumes from the same phase.

Top module: `frc_freerun`

## Requirements
- R1: After reset, `count_o` is zero and the prescaler phase is cleared. A reset asserted while the counter is running returns `count_o` to zero.
- R2: While `cnt_en_i` is 0, `count_o` keeps its last value and is not cleared. Changes on `presc_i` have no visible effect in that time.
- R3: On the first rising clock edge at which `cnt_en_i` is sampled 1 after having been 0, `count_o` increments by one, unless the counter is frozen.
- R4: After that first increment, while enabled and not frozen, `count_o` increments once every (`presc_i` + 1) clocks. A prescale value of 0 gives one increment per clock.
- R5: A new `presc_i` value takes effect only after the prescale period in progress has ended.
- R6: While `halt_sel_i` = 1 and `dbg_halt_i` = 1, `count_o` and the prescaler phase hold. After release, the remaining part of the period runs out before the next increment.
- R7: While `halt_sel_i` = 0, `dbg_halt_i` has no effect on counting.
- R8: `count_o` wraps from all ones to zero and keeps counting. The wrap produces no other indication.
- R9: Any change of `count_o` outside reset is an increment of exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_en_i | input | 1 | Counter enable from the control register |
| presc_i | input | PRESC_W | Prescale value; the tick period is presc_i + 1 clocks |
| halt_sel_i | input | 1 | Debug-halt select shared with the countdown timer |
| dbg_halt_i | input | 1 | Processor is in debug halt |
| count_o | output | CNT_W | Current count value |

## Verification
The bench builds the block with CNT_W = 12 and PRESC_W = 8. The 12-bit count width makes the all-ones to zero wrap reachable in a few thousand clocks at prescale 0, which a 32-bit count would not allow. The 8-bit prescaler keeps the full prescale range available, so random periods and mid-period prescale changes land on many different phases. The halt variant is enabled, so freeze and release are exercised against the running phase.

// File: rtl/frc_pkg.sv
package frc_pkg;

   // Gated control seen by the prescaler
   typedef struct packed {
      logic run;     // counting permitted by software enable
      logic freeze;  // debug halt hold in effect
   } frc_ctl_t;

endpackage

// File: rtl/frc_ctl_gate.sv
module frc_ctl_gate
   import frc_pkg::*;
#(
   parameter bit HALT_EN = 1'b1
) (
   input  logic     cnt_en_i,
   input  logic     halt_sel_i,
   input  logic     dbg_halt_i,
   output frc_ctl_t ctl_o
);

   generate
      if (HALT_EN) begin : g_halt
         assign ctl_o.freeze = halt_sel_i & dbg_halt_i;
      end else begin : g_nohalt
         logic unused_halt;
         assign unused_halt  = halt_sel_i ^ dbg_halt_i;
         assign ctl_o.freeze = 1'b0;
      end
   endgenerate

   assign ctl_o.run = cnt_en_i;

endmodule

// File: rtl/frc_prescaler.sv
module frc_prescaler
   import frc_pkg::*;
#(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  frc_ctl_t           ctl_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               tick_o
);

   localparam logic [PRESC_W-1:0] PH_ZERO = '0;

   logic [PRESC_W-1:0] phase_q;

   assign tick_o = ctl_i.run & ~ctl_i.freeze & (phase_q == PH_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_ZERO;
      end else if (!ctl_i.run) begin
         phase_q <= PH_ZERO;
      end else if (!ctl_i.freeze) begin
         if (tick_o) begin
            phase_q <= presc_i;
         end else begin
            phase_q <= phase_q - 1'b1;
         end
      end
   end

   // R6
   freeze_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.run && ctl_i.freeze) |=> $stable(phase_q));

   // R2
   idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.run) |=> (phase_q == PH_ZERO));

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

   // R9
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/frc_freerun.sv
module frc_freerun
   import frc_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRESC_W = 8,
   parameter bit HALT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cnt_en_i,
   input  logic [PRESC_W-1:0] presc_i,
   input  logic               halt_sel_i,
   input  logic               dbg_halt_i,
   output logic [CNT_W-1:0]   count_o
);

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("frc_freerun: CNT_W must lie in 2..64");
      end
      if (PRESC_W < 1 || PRESC_W > 16) begin : g_bad_presc_w
         $error("frc_freerun: PRESC_W must lie in 1..16");
      end
   endgenerate

   frc_ctl_t ctl;
   logic     tick;

   frc_ctl_gate #(.HALT_EN(HALT_EN)) ctl_gate_i (
      .cnt_en_i   (cnt_en_i),
      .halt_sel_i (halt_sel_i),
      .dbg_halt_i (dbg_halt_i),
      .ctl_o      (ctl)
   );

   frc_prescaler #(.PRESC_W(PRESC_W)) presc_i_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_i   (ctl),
      .presc_i (presc_i),
      .tick_o  (tick)
   );

   frc_counter #(.CNT_W(CNT_W)) cnt_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .count_o (count_o)
   );

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en_i) |=> $stable(count_o));

   // R3
   first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_i && !$past(cnt_en_i) && !ctl.freeze)
         |=> (count_o == $past(count_o) + 1'b1));

   generate
      if (HALT_EN) begin : g_halt_chk
         // R6
         halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (halt_sel_i && dbg_halt_i) |=> $stable(count_o));
      end
   endgenerate

endmodule

// File: tb/frc_freerun_tb_top.sv
module frc_freerun_tb_top;

   localparam int CW = 12;
   localparam int PW = 8;
   localparam logic [CW-1:0] CMAX = '1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cnt_en_i;
   logic [PW-1:0] presc_i;
   logic          halt_sel_i;
   logic          dbg_halt_i;
   logic [CW-1:0] count_o;

   always #5 clk = ~clk;

   frc_freerun #(.CNT_W(CW), .PRESC_W(PW), .HALT_EN(1'b1)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_en_i   (cnt_en_i),
      .presc_i    (presc_i),
      .halt_sel_i (halt_sel_i),
      .dbg_halt_i (dbg_halt_i),
      .count_o    (count_o)
   );

   int            n_chk  = 0;
   int            n_fail = 0;
   logic [CW-1:0] m_cnt  = '0;
   int            m_wait = 0;
   bit            done   = 1'b0;

   function automatic bit frozen(input logic sel, input logic dbg);
      return sel && dbg;
   endfunction

   function automatic int reload(input logic [PW-1:0] p);
      return int'(p);
   endfunction

   task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: count_o actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One clock: update the behavioural expectation at the edge, compare at the falling edge
   task automatic step(input string req);
      @(posedge clk);
      if (!rst_n) begin
         m_cnt  = '0;
         m_wait = 0;
      end else if (!cnt_en_i) begin
         m_wait = 0;
      end else if (!frozen(halt_sel_i, dbg_halt_i)) begin
         if (m_wait == 0) begin
            m_cnt  = m_cnt + 1'b1;
            m_wait = reload(presc_i);
         end else begin
            m_wait--;
         end
      end
      @(negedge clk);
      chk(req, count_o, m_cnt);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] base;
      void'($urandom(32'd4711));
      rst_n = 1'b0; cnt_en_i = 1'b0; presc_i = 8'h3E;
      halt_sel_i = 1'b0; dbg_halt_i = 1'b0;
      repeat (3) step("R1 reset");
      rst_n = 1'b1;
      chk("R1 reset value", count_o, '0);

      // R3 first increment, R4 spacing with prescale 3
      presc_i = 8'd3; cnt_en_i = 1'b1;
      step("R3 first tick");
      chk("R3 immediate increment", count_o, 12'd1);
      repeat (3) step("R4 period");
      chk("R4 still mid period", count_o, 12'd1);
      step("R4 period end");
      chk("R4 period of presc+1", count_o, 12'd2);

      // R2 disabled: hold, prescale ignored
      cnt_en_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
         presc_i = 8'(i);
         step("R2 idle");
      end
      chk("R2 value kept while disabled", count_o, 12'd2);

      // R5 prescale change mid period
      presc_i = 8'd1; cnt_en_i = 1'b1;
      step("R3 re-enable");
      chk("R3 re-enable tick", count_o, 12'd3);
      presc_i = 8'd4;
      step("R5 old period");
      chk("R5 old period running", count_o, 12'd3);
      step("R5 old period end");
      chk("R5 old period completes", count_o, 12'd4);
      repeat (4) step("R5 new period");
      chk("R5 new period mid", count_o, 12'd4);
      step("R5 new period end");
      chk("R5 new period applies", count_o, 12'd5);

      // R6 freeze and resume
      presc_i = 8'd2;
      repeat (2) step("R4 run");
      base = count_o;
      halt_sel_i = 1'b1; dbg_halt_i = 1'b1;
      repeat (10) step("R6 frozen");
      chk("R6 frozen value", count_o, base);
      dbg_halt_i = 1'b0;
      repeat (7) step("R6 resume");

      // R7 debug halt without select
      halt_sel_i = 1'b0; dbg_halt_i = 1'b1; presc_i = 8'd0;
      repeat (3) step("R7 settle");
      base = count_o;
      repeat (5) step("R7 not halted");
      chk("R7 halt ignored", count_o, base + 12'd5);
      dbg_halt_i = 1'b0;

      // R8 wrap
      for (int i = 0; i < 5000 && count_o != CMAX; i++) step("R8 approach");
      chk("R8 reached all ones", count_o, CMAX);
      step("R8 wrap");
      chk("R8 wrap to zero", count_o, '0);
      step("R8 after wrap");
      chk("R8 continues", count_o, 12'd1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 15) == 0) cnt_en_i = ~cnt_en_i;
         if ($urandom_range(0, 7) == 0) presc_i = 8'($urandom_range(0, 6));
         if ($urandom_range(0, 31) == 0) presc_i = 8'($urandom_range(0, 255));
         if ($urandom_range(0, 19) == 0) halt_sel_i = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 9) == 0) dbg_halt_i = 1'($urandom_range(0, 1));
         step("R4 random");
      end

      // R1 reset while running
      cnt_en_i = 1'b1; presc_i = 8'd0; halt_sel_i = 1'b0;
      repeat (3) step("R4 run");
      rst_n = 1'b0;
      step("R1 mid-run reset");
      chk("R1 cleared by reset", count_o, '0);
      rst_n = 1'b1;
      step("R3 after reset");

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule